// File: doc/BRIEF.md
# Multi-Cycle Execute Stage

This block is the execute stage of a small 32-bit three-stage pipelined processor. It accepts one instruction at a time from decode. The instruction is a word store, a signed multiply-high, or an absolute branch-and-link. The unit holds the instruction until a latency given with it has run out, and reports a stall on each cycle of that wait. It then carries out the operation through a register-file port, the program-counter and status-register write ports, and a data-memory write handshake. Each cycle it reports a 3-bit status code.

A store whose memory side is still busy stays in the stage and reports a memory-busy code on each busy cycle. It retries the same write until memory accepts it or reports a mapped region. A store to an address that is not word aligned never reaches memory. Instead it loads the exception status word and the exception address. The branch links the current PC into the destination register and sets bit 3 of the machine status register.

Top module: `xstage_exec`

## Requirements
- R1: With issue latency L (0 counts as 1), the unit reports STALL (code 1) on the L-1 cycles after acceptance. It asserts no register, PC, MSR, ESR or EAR write during those cycles, and then performs the operation.
- R2: The wait count restarts from 1 for every accepted instruction, so an instruction issued after another sees the full stall count of its own latency.
- R3: A store (op 0) drives address rA + sign-extended 16-bit immediate and data rD with mem_req high. A READY response (mem_resp 0) completes it with status NORMAL (code 0).
- R4: A BUSY response (mem_resp 1) gives status MEM_ACCESS (code 2) for that cycle without restarting the wait. The same request is presented again on the next cycle.
- R5: A store whose address has either of bits [1:0] set never raises mem_req. It writes ESR with 0xC00 OR (rD index << 5) and EAR with the address, and reports MEM_UNALIGNED (code 3).
- R6: A MAPPED response (mem_resp 2) writes EAR with the address, leaves ESR unwritten and reports MEM_MAPPED (code 4).
- R7: Multiply-high (op 1) writes into rD the upper 32 bits of the signed 64-bit product of rA and rB, with status NORMAL.
- R8: Branch-and-link (op 2) writes the current PC into rD, writes PC with the sign-extended immediate, writes MSR with its input value OR 0x8, and reports JUMP (code 5).
- R9: After reset the status is NORMAL, issue_ready is high and no write strobe is active.
- R10: issue_ready stays low from acceptance until the cycle on which a completing or faulting status is reported. An issue_valid presented meanwhile, with other fields, does not affect the instruction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | New instruction offered |
| issue_op | input | 2 | 0 store, 1 multiply-high, 2 branch-and-link |
| issue_rd | input | 5 | Destination / store-data register index |
| issue_ra | input | 5 | First source register index |
| issue_rb | input | 5 | Second source register index |
| issue_imm | input | 16 | Immediate, sign-extended |
| issue_lat | input | 4 | Latency of the instruction in cycles |
| issue_ready | output | 1 | Stage free to accept |
| rf_ra_addr | output | 5 | Read address for rA |
| rf_rb_addr | output | 5 | Read address for rB |
| rf_rd_addr | output | 5 | Read address for rD |
| rf_ra_data | input | 32 | rA value |
| rf_rb_data | input | 32 | rB value |
| rf_rd_data | input | 32 | rD value |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write value |
| pc_in | input | 32 | Current PC |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 32 | New PC |
| msr_in | input | 32 | Current MSR |
| msr_we | output | 1 | MSR write strobe |
| msr_wdata | output | 32 | New MSR |
| esr_we | output | 1 | ESR write strobe |
| esr_wdata | output | 32 | New ESR |
| ear_we | output | 1 | EAR write strobe |
| ear_wdata | output | 32 | Faulting address |
| mem_req | output | 1 | Store request, answered in the same cycle |
| mem_addr | output | 32 | Store address |
| mem_wdata | output | 32 | Store data |
| mem_resp | input | 2 | 0 READY, 1 BUSY, 2 MAPPED |
| status | output | 3 | Cycle status code |

## Verification
Multiply-high is driven with mixed-sign operands and with the most negative value squared. A signed product is told apart from an unsigned one only by these inputs. Stores are aimed at aligned normal, misaligned and mapped addresses with zero to three busy cycles, which separates the three fault paths and shows that the wait count is not restarted during memory retries. Latencies of 0, 1 and larger, given to back-to-back instructions, show whether the count restarts from 1 and whether a latency of 0 is clamped. Junk issues offered while the stage is busy show whether the held instruction can be overwritten.

// File: rtl/xs_pkg.sv
package xs_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL   = 3'd0,
    ST_STALL    = 3'd1,
    ST_MEM_BUSY = 3'd2,
    ST_UNALIGN  = 3'd3,
    ST_MAPPED   = 3'd4,
    ST_JUMP     = 3'd5
  } xs_status_e;

  typedef enum logic [1:0] {
    OP_STW  = 2'd0,
    OP_MULH = 2'd1,
    OP_BAL  = 2'd2,
    OP_RSV  = 2'd3
  } xs_op_e;

  typedef enum logic [1:0] {
    MR_READY  = 2'd0,
    MR_BUSY   = 2'd1,
    MR_MAPPED = 2'd2,
    MR_RSV    = 2'd3
  } xs_mresp_e;
endpackage

// File: rtl/xs_lat_ctr.sv
module xs_lat_ctr #(
  parameter int RIDX = 5,
  parameter int IMMW = 16,
  parameter int LATW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue_valid,
  input  xs_pkg::xs_op_e      issue_op,
  input  logic [RIDX-1:0]     issue_rd,
  input  logic [RIDX-1:0]     issue_ra,
  input  logic [RIDX-1:0]     issue_rb,
  input  logic [IMMW-1:0]     issue_imm,
  input  logic [LATW-1:0]     issue_lat,
  input  logic                retire,
  output logic                busy,
  output logic                go,
  output xs_pkg::xs_op_e      op_q,
  output logic [RIDX-1:0]     rd_q,
  output logic [RIDX-1:0]     ra_q,
  output logic [RIDX-1:0]     rb_q,
  output logic [IMMW-1:0]     imm_q
);
  import xs_pkg::*;

  logic [LATW-1:0] lat_q;
  logic [LATW-1:0] cnt_q;
  logic [LATW-1:0] lat_eff;

  // a zero latency behaves as a single cycle
  assign lat_eff = (lat_q == '0) ? LATW'(1) : lat_q;
  assign go      = busy && (cnt_q >= lat_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= LATW'(1);
      lat_q <= '0;
      op_q  <= OP_RSV;
      rd_q  <= '0;
      ra_q  <= '0;
      rb_q  <= '0;
      imm_q <= '0;
    end else if (!busy) begin
      if (issue_valid) begin
        busy  <= 1'b1;
        cnt_q <= LATW'(1);
        lat_q <= issue_lat;
        op_q  <= issue_op;
        rd_q  <= issue_rd;
        ra_q  <= issue_ra;
        rb_q  <= issue_rb;
        imm_q <= issue_imm;
      end
    end else if (retire) begin
      busy  <= 1'b0;
      cnt_q <= LATW'(1);
    end else if (!go) begin
      cnt_q <= cnt_q + LATW'(1);
    end
  end

  // R1: the wait count never runs past the effective latency
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= lat_eff));

  // R2: a freshly accepted instruction starts counting at one
  p_fresh_count_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cnt_q == LATW'(1)));

  // R10: the held instruction is not replaced before it retires
  p_hold_instr_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !retire) |=> (busy && $stable(op_q) && $stable(rd_q) &&
                           $stable(ra_q) && $stable(imm_q)));
endmodule

// File: rtl/xs_alu.sv
module xs_alu #(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] imm_sx,
  output logic [XLEN-1:0] eff_addr,
  output logic            misaligned,
  output logic [XLEN-1:0] mul_hi
);
  localparam int ALIGNW = $clog2(XLEN / 8);

  logic signed [2*XLEN-1:0] prod;

  assign imm_sx     = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign eff_addr   = ra_val + imm_sx;
  assign misaligned = |eff_addr[ALIGNW-1:0];
  assign prod       = $signed({{XLEN{ra_val[XLEN-1]}}, ra_val}) *
                      $signed({{XLEN{rb_val[XLEN-1]}}, rb_val});
  assign mul_hi     = prod[2*XLEN-1:XLEN];
endmodule

// File: rtl/xstage_exec.sv
module xstage_exec #(
  parameter int XLEN       = 32,
  parameter int RIDX       = 5,
  parameter int IMMW       = 16,
  parameter int LATW       = 4,
  parameter int LINK_BIT   = 3,
  parameter int ESR_RD_POS = 5,
  parameter logic [XLEN-1:0] ESR_TAG = 32'h0000_0C00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  input  logic [1:0]      issue_op,
  input  logic [RIDX-1:0] issue_rd,
  input  logic [RIDX-1:0] issue_ra,
  input  logic [RIDX-1:0] issue_rb,
  input  logic [IMMW-1:0] issue_imm,
  input  logic [LATW-1:0] issue_lat,
  output logic            issue_ready,
  output logic [RIDX-1:0] rf_ra_addr,
  output logic [RIDX-1:0] rf_rb_addr,
  output logic [RIDX-1:0] rf_rd_addr,
  input  logic [XLEN-1:0] rf_ra_data,
  input  logic [XLEN-1:0] rf_rb_data,
  input  logic [XLEN-1:0] rf_rd_data,
  output logic            rf_we,
  output logic [RIDX-1:0] rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  input  logic [XLEN-1:0] pc_in,
  output logic            pc_we,
  output logic [XLEN-1:0] pc_wdata,
  input  logic [XLEN-1:0] msr_in,
  output logic            msr_we,
  output logic [XLEN-1:0] msr_wdata,
  output logic            esr_we,
  output logic [XLEN-1:0] esr_wdata,
  output logic            ear_we,
  output logic [XLEN-1:0] ear_wdata,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [1:0]      mem_resp,
  output logic [2:0]      status
);
  import xs_pkg::*;

  localparam int ALIGNW = $clog2(XLEN / 8);
  localparam logic [XLEN-1:0] LINK_MASK = XLEN'(1) << LINK_BIT;

  logic            busy, go, retire;
  xs_op_e          op_q;
  logic [RIDX-1:0] rd_q, ra_q, rb_q;
  logic [IMMW-1:0] imm_q;
  logic [XLEN-1:0] imm_sx, eff_addr, mul_hi;
  logic            misaligned;
  xs_mresp_e       resp;

  xs_lat_ctr #(.RIDX(RIDX), .IMMW(IMMW), .LATW(LATW)) u_ctr (
    .clk(clk), .rst(rst),
    .issue_valid(issue_valid), .issue_op(xs_op_e'(issue_op)),
    .issue_rd(issue_rd), .issue_ra(issue_ra), .issue_rb(issue_rb),
    .issue_imm(issue_imm), .issue_lat(issue_lat),
    .retire(retire), .busy(busy), .go(go), .op_q(op_q),
    .rd_q(rd_q), .ra_q(ra_q), .rb_q(rb_q), .imm_q(imm_q)
  );

  xs_alu #(.XLEN(XLEN), .IMMW(IMMW)) u_alu (
    .ra_val(rf_ra_data), .rb_val(rf_rb_data), .imm(imm_q),
    .imm_sx(imm_sx), .eff_addr(eff_addr), .misaligned(misaligned),
    .mul_hi(mul_hi)
  );

  assign issue_ready = !busy;
  assign rf_ra_addr  = ra_q;
  assign rf_rb_addr  = rb_q;
  assign rf_rd_addr  = rd_q;
  assign resp        = xs_mresp_e'(mem_resp);
  assign mem_req     = go && (op_q == OP_STW) && !misaligned;
  assign mem_addr    = eff_addr;
  assign mem_wdata   = rf_rd_data;

  // next-cycle outputs
  xs_status_e      st_d, st_q;
  logic            rf_we_d, pc_we_d, msr_we_d, esr_we_d, ear_we_d;
  logic [XLEN-1:0] rf_wdata_d;

  always_comb begin
    st_d       = ST_NORMAL;
    retire     = 1'b0;
    rf_we_d    = 1'b0;
    pc_we_d    = 1'b0;
    msr_we_d   = 1'b0;
    esr_we_d   = 1'b0;
    ear_we_d   = 1'b0;
    rf_wdata_d = mul_hi;
    if (busy) begin
      if (!go) begin
        st_d = ST_STALL;
      end else begin
        unique case (op_q)
          OP_STW: begin
            if (misaligned) begin
              st_d     = ST_UNALIGN;
              esr_we_d = 1'b1;
              ear_we_d = 1'b1;
              retire   = 1'b1;
            end else if (resp == MR_BUSY) begin
              st_d = ST_MEM_BUSY;
            end else if (resp == MR_MAPPED) begin
              st_d     = ST_MAPPED;
              ear_we_d = 1'b1;
              retire   = 1'b1;
            end else begin
              retire = 1'b1;
            end
          end
          OP_MULH: begin
            rf_we_d = 1'b1;
            retire  = 1'b1;
          end
          OP_BAL: begin
            st_d       = ST_JUMP;
            rf_we_d    = 1'b1;
            rf_wdata_d = pc_in;
            pc_we_d    = 1'b1;
            msr_we_d   = 1'b1;
            retire     = 1'b1;
          end
          default: retire = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_NORMAL;
      rf_we     <= 1'b0;
      pc_we     <= 1'b0;
      msr_we    <= 1'b0;
      esr_we    <= 1'b0;
      ear_we    <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      pc_wdata  <= '0;
      msr_wdata <= '0;
      esr_wdata <= '0;
      ear_wdata <= '0;
    end else begin
      st_q      <= st_d;
      rf_we     <= rf_we_d;
      pc_we     <= pc_we_d;
      msr_we    <= msr_we_d;
      esr_we    <= esr_we_d;
      ear_we    <= ear_we_d;
      rf_waddr  <= rd_q;
      rf_wdata  <= rf_wdata_d;
      pc_wdata  <= imm_sx;
      msr_wdata <= msr_in | LINK_MASK;
      esr_wdata <= ESR_TAG | (XLEN'(rd_q) << ESR_RD_POS);
      ear_wdata <= eff_addr;
    end
  end

  assign status = st_q;

  // R1: a stall cycle writes nothing
  p_stall_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STALL) |-> !(rf_we || pc_we || msr_we || esr_we || ear_we));

  // R4: a busy memory keeps the stage occupied
  p_busy_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_MEM_BUSY) |-> !issue_ready);

  // R5: memory only ever sees word-aligned stores
  p_aligned_req_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ALIGNW-1:0] == '0));

  // R5: an ESR load always comes with an EAR load and the unaligned code
  p_fault_pair_r5: assert property (@(posedge clk) disable iff (rst)
    esr_we |-> (ear_we && st_q == ST_UNALIGN));

  // R6: a mapped fault loads EAR only
  p_mapped_ear_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_MAPPED) |-> (ear_we && !esr_we && !rf_we));

  // R8: a PC write is always accompanied by the link and MSR writes
  p_jump_side_r8: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> (msr_we && rf_we && st_q == ST_JUMP));
endmodule

// File: tb/xstage_exec_tb.sv
`timescale 1ns/1ps
module xstage_exec_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [1:0]  issue_op = '0;
  logic [4:0]  issue_rd = '0, issue_ra = '0, issue_rb = '0;
  logic [15:0] issue_imm = '0;
  logic [3:0]  issue_lat = '0;
  logic        issue_ready;
  logic [4:0]  rf_ra_addr, rf_rb_addr, rf_rd_addr, rf_waddr;
  logic [31:0] rf_ra_data, rf_rb_data, rf_rd_data, rf_wdata;
  logic        rf_we, pc_we, msr_we, esr_we, ear_we, mem_req;
  logic [31:0] pc_wdata, msr_wdata, esr_wdata, ear_wdata, mem_addr, mem_wdata;
  logic [31:0] pc_in = 32'h0000_1000, msr_in = 32'h0000_0001;
  logic [1:0]  mem_resp = 2'd0;
  logic [2:0]  status;

  logic [31:0] rf [32];
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  assign rf_ra_data = rf[rf_ra_addr];
  assign rf_rb_data = rf[rf_rb_addr];
  assign rf_rd_data = rf[rf_rd_addr];

  xstage_exec u_dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_rd(issue_rd), .issue_ra(issue_ra), .issue_rb(issue_rb),
    .issue_imm(issue_imm), .issue_lat(issue_lat), .issue_ready(issue_ready),
    .rf_ra_addr(rf_ra_addr), .rf_rb_addr(rf_rb_addr), .rf_rd_addr(rf_rd_addr),
    .rf_ra_data(rf_ra_data), .rf_rb_data(rf_rb_data), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .pc_in(pc_in), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .msr_in(msr_in), .msr_we(msr_we), .msr_wdata(msr_wdata),
    .esr_we(esr_we), .esr_wdata(esr_wdata), .ear_we(ear_we), .ear_wdata(ear_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_resp(mem_resp), .status(status)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] mulh_ref(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] p;
    p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    return p[63:32];
  endfunction

  // kind: 0 normal store, 1 unaligned, 2 mapped, 3 mulh, 4 bal
  task automatic run_instr(input logic [1:0] op, input logic [4:0] rd,
                           input logic [4:0] ra, input logic [4:0] rb,
                           input logic [15:0] imm, input logic [3:0] lat,
                           input int wait_cyc, input bit junk);
    logic [31:0] a, b, d, addr;
    int lp, kind, term, left, req_seen;
    bit quiet, rdy_low, req_ok, done;
    logic [2:0] exp_st;
    a = rf[ra]; b = rf[rb]; d = rf[rd];
    addr = a + sx16(imm);
    lp = (lat == 0) ? 1 : int'(lat);
    if (op == 2'd0)
      kind = (addr[1:0] != 2'b00) ? 1 : ((addr[31:28] == 4'hF) ? 2 : 0);
    else
      kind = (op == 2'd1) ? 3 : 4;
    term = lp + ((kind == 0) ? wait_cyc : 0);
    left = wait_cyc;
    req_seen = 0; quiet = 1; rdy_low = 1; req_ok = 1; done = 0;

    check(issue_ready === 1'b1, "R10 ready before issue", 64'(issue_ready), 64'd1);
    issue_valid = 1'b1; issue_op = op; issue_rd = rd; issue_ra = ra;
    issue_rb = rb; issue_imm = imm; issue_lat = lat;
    @(negedge clk);
    if (junk) begin
      issue_op = 2'd2; issue_rd = ~rd; issue_ra = ~ra; issue_rb = ~rb;
      issue_imm = ~imm; issue_lat = 4'd1;
    end else begin
      issue_valid = 1'b0;
    end
    for (int i = 1; i <= 40 && !done; i++) begin
      if (mem_req === 1'b1) begin
        req_seen++;
        if (mem_addr !== addr || mem_wdata !== d) req_ok = 0;
        if (mem_addr[31:28] == 4'hF) mem_resp = 2'd2;
        else if (left > 0) begin mem_resp = 2'd1; left--; end
        else mem_resp = 2'd0;
      end else begin
        mem_resp = 2'd0;
      end
      @(negedge clk);
      if (i < lp) exp_st = 3'd1;
      else if (i < term) exp_st = 3'd2;
      else begin
        case (kind)
          0: exp_st = 3'd0;
          1: exp_st = 3'd3;
          2: exp_st = 3'd4;
          3: exp_st = 3'd0;
          default: exp_st = 3'd5;
        endcase
      end
      check(status === exp_st, (i < lp) ? "R1 stall status" :
            (i < term) ? "R4 busy status" : "R2/R3/R5-R8 final status",
            64'(status), 64'(exp_st));
      if (i < lp && (rf_we || pc_we || msr_we || esr_we || ear_we)) quiet = 0;
      if (i >= term) begin
        done = 1;
        issue_valid = 1'b0;
      end else if (issue_ready !== 1'b0) rdy_low = 0;
    end
    check(done, "watch instruction end", 64'(done), 64'd1);
    check(quiet, "R1 no writes while stalling", 64'(quiet), 64'd1);
    check(rdy_low && issue_ready === 1'b1, "R10 ready low while busy",
          64'(rdy_low), 64'd1);
    case (kind)
      0: begin
        check(req_ok && req_seen == wait_cyc + 1, "R3 R4 store request",
              64'(req_seen), 64'(wait_cyc + 1));
        check(!rf_we && !esr_we && !ear_we, "R3 store side effects",
              64'({rf_we, esr_we, ear_we}), 64'd0);
      end
      1: begin
        check(req_seen == 0, "R5 no request when misaligned", 64'(req_seen), 64'd0);
        check(esr_we && esr_wdata === (32'hC00 | (32'(rd) << 5)), "R5 ESR",
              64'(esr_wdata), 64'(32'hC00 | (32'(rd) << 5)));
        check(ear_we && ear_wdata === addr, "R5 EAR", 64'(ear_wdata), 64'(addr));
      end
      2: begin
        check(ear_we && !esr_we && ear_wdata === addr, "R6 mapped EAR",
              {31'd0, esr_we, ear_wdata}, 64'(addr));
      end
      3: begin
        check(rf_we && rf_waddr === rd && rf_wdata === mulh_ref(a, b),
              "R7 multiply high", 64'(rf_wdata), 64'(mulh_ref(a, b)));
      end
      default: begin
        check(rf_we && rf_waddr === rd && rf_wdata === pc_in, "R8 link",
              64'(rf_wdata), 64'(pc_in));
        check(pc_we && pc_wdata === sx16(imm), "R8 target",
              64'(pc_wdata), 64'(sx16(imm)));
        check(msr_we && msr_wdata === (msr_in | 32'h8), "R8 MSR",
              64'(msr_wdata), 64'(msr_in | 32'h8));
      end
    endcase
    if (rf_we) rf[rf_waddr] = rf_wdata;
    if (pc_we) pc_in = pc_wdata;
    if (msr_we) msr_in = msr_wdata;
    mem_resp = 2'd0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 32; k++) rf[k] = 32'h100 * k;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(status === 3'd0, "R9 reset status", 64'(status), 64'd0);
    check(issue_ready === 1'b1, "R9 reset ready", 64'(issue_ready), 64'd1);
    check(!(rf_we || pc_we || msr_we || esr_we || ear_we || mem_req),
          "R9 reset strobes", 64'(rf_we), 64'd0);

    // R7 signed operands
    rf[1] = 32'hFFFF_FFFD; rf[2] = 32'd5;
    run_instr(2'd1, 5'd3, 5'd1, 5'd2, 16'd0, 4'd1, 0, 0);
    rf[1] = 32'h8000_0000; rf[2] = 32'h8000_0000;
    run_instr(2'd1, 5'd4, 5'd1, 5'd2, 16'd0, 4'd3, 0, 0);
    // R3 R4 aligned store with busy memory
    rf[5] = 32'h1000_0100; rf[6] = 32'hCAFE_F00D;
    run_instr(2'd0, 5'd6, 5'd5, 5'd0, 16'hFFFC, 4'd3, 2, 0);
    // R5 misaligned store
    run_instr(2'd0, 5'd6, 5'd5, 5'd0, 16'h0002, 4'd2, 0, 0);
    // R6 mapped store
    rf[7] = 32'hF000_0040;
    run_instr(2'd0, 5'd6, 5'd7, 5'd0, 16'h0004, 4'd1, 1, 0);
    // R8 branch with latency zero, R10 junk issue while busy
    run_instr(2'd2, 5'd9, 5'd0, 5'd0, 16'h8010, 4'd0, 0, 0);
    run_instr(2'd1, 5'd10, 5'd1, 5'd2, 16'd0, 4'd5, 0, 1);
    // R2 back-to-back with identical latency
    run_instr(2'd1, 5'd11, 5'd3, 5'd4, 16'd0, 4'd4, 0, 0);
    run_instr(2'd1, 5'd12, 5'd3, 5'd4, 16'd0, 4'd4, 0, 0);

    for (int n = 0; n < 150; n++) begin
      logic [1:0] op;
      logic [4:0] rd, ra, rb;
      op = 2'($urandom_range(0, 2));
      rd = 5'($urandom); ra = 5'($urandom); rb = 5'($urandom);
      if (op == 2'd0 && ra != rd) begin
        rf[ra] = {($urandom_range(0, 3) == 0) ? 4'hF : 4'h2, 28'($urandom)};
        rf[rd] = $urandom;
      end else if (op == 2'd1) begin
        rf[ra] = $urandom; if (rb != ra) rf[rb] = $urandom;
      end
      run_instr(op, rd, ra, rb, 16'($urandom), 4'($urandom_range(0, 6)),
                $urandom_range(0, 3), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule